// File: doc/BRIEF.md
# Saturating Monitor Mix Path

This block folds a scaled copy of the incoming stereo capture samples into the stereo playback samples. Both channels of the capture pair are attenuated by one shared 4-bit code, where every code step is a 6 dB cut made by an arithmetic right shift of the signed 16-bit sample. The top code silences the monitor contribution entirely. The scaled pair is then added to the playback pair. The sum feeds a later output attenuator, which means the mixed capture signal is attenuated a second time downstream.

All arithmetic is on 16-bit two's-complement linear samples. The addition is carried out one bit wider than the samples, and a sum that leaves the 16-bit range is clamped to the nearest full-scale value. It never wraps. The block only reads the capture samples and returns nothing on that path, so the capture stream sent to the serial port is unaffected. The result is registered, and the output strobe follows the input strobe one cycle later.

Top module: `mon_mix_path`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `out_valid` becomes 0 and both mixed outputs become 0 after that edge.
- R2: `out_valid` after a rising edge equals `in_valid` sampled at that edge.
- R3: For a code n from 0 to 14, the capture contribution is the signed capture sample arithmetically shifted right by n bits (rounding toward minus infinity), so code 0 passes it unscaled.
- R4: Code 15 (all ones) mutes the contribution, and each mixed output equals its playback sample exactly.
- R5: The single code applies to both channels: left mix uses only left capture and left playback, and right mix uses only right capture and right playback.
- R6: A sum above +32767 is output as +32767 (0x7FFF); two non-negative operands never give a negative result.
- R7: A sum below -32768 is output as -32768 (0x8000); two negative operands never give a non-negative result.
- R8: A rising edge with `in_valid` low leaves both mixed outputs unchanged.
- R9: Mixed outputs for samples presented with `in_valid` high at a rising edge appear right after that same edge (one register stage).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A new sample set is present on the inputs |
| adc_left | input | 16 | Left capture sample, two's complement |
| adc_right | input | 16 | Right capture sample, two's complement |
| dac_left | input | 16 | Left playback sample, two's complement |
| dac_right | input | 16 | Right playback sample, two's complement |
| mon_code | input | 4 | Monitor attenuation code, 6 dB per step, 15 mutes |
| out_valid | output | 1 | Mixed pair updated on the previous edge |
| mix_left | output | 16 | Left mixed sample, saturated |
| mix_right | output | 16 | Right mixed sample, saturated |

## Verification
Scaling by shift and full-scale clamping can fall in the same cycle, and the two channels can clamp in opposite directions in that same cycle. The bench sweeps every code against capture and playback values at and near both full-scale limits, feeding the right channel the bitwise inverse of the left operands, so that one channel clips high while the other clips low. Each result is judged against a sum computed in wide integer arithmetic and clamped in the bench.

// File: rtl/mon_mix_pkg.sv
// Shared constants for the monitor mix path.
// Assumes a stereo stream; channel indices are fixed by the top-level mapping.
package mon_mix_pkg;
    localparam int unsigned NUM_CH       = 2;
    localparam int unsigned CH_LEFT      = 0;
    localparam int unsigned CH_RIGHT     = 1;
    localparam int unsigned DEF_SAMPLE_W = 16;
    localparam int unsigned DEF_CODE_W   = 4;
endpackage

// File: rtl/mon_mix_atten.sv
// Monitor attenuator: scales one signed sample by 6 dB per code step.
// Each step is an arithmetic right shift by one bit; the all-ones code mutes.
// Assumes the largest non-mute shift is below SAMPLE_W.
module mon_mix_atten #(
    parameter int unsigned SAMPLE_W = 16,
    parameter int unsigned CODE_W   = 4
) (
    input  logic signed [SAMPLE_W-1:0] sample_i,
    input  logic        [CODE_W-1:0]   code_i,
    output logic signed [SAMPLE_W-1:0] scaled_o
);
    localparam logic [CODE_W-1:0] MUTE_CODE = {CODE_W{1'b1}};

    // Shift right by the code, or force zero on the mute code.
    always_comb begin
        if (code_i == MUTE_CODE) begin
            scaled_o = '0;
        end else begin
            scaled_o = sample_i >>> code_i;
        end
    end
endmodule

// File: rtl/mon_mix_satadd.sv
// Saturating signed adder: adds two samples one bit wider than they are,
// then clamps to the signed full-scale range when the top two bits disagree.
// Assumes both operands are two's-complement of the same width.
module mon_mix_satadd #(
    parameter int unsigned SAMPLE_W = 16
) (
    input  logic signed [SAMPLE_W-1:0] a_i,
    input  logic signed [SAMPLE_W-1:0] b_i,
    output logic signed [SAMPLE_W-1:0] sum_o
);
    localparam int unsigned EXT_W = SAMPLE_W + 1;
    localparam logic signed [SAMPLE_W-1:0] POS_FS = {1'b0, {(SAMPLE_W-1){1'b1}}};
    localparam logic signed [SAMPLE_W-1:0] NEG_FS = {1'b1, {(SAMPLE_W-1){1'b0}}};

    logic signed [EXT_W-1:0] wide_sum;
    logic                    overflow;

    // Form the widened sum so no carry is lost.
    always_comb begin
        wide_sum = {a_i[SAMPLE_W-1], a_i} + {b_i[SAMPLE_W-1], b_i};
        overflow = wide_sum[EXT_W-1] ^ wide_sum[EXT_W-2];
    end

    // Clamp toward the sign of the true sum on overflow.
    always_comb begin
        if (overflow) begin
            sum_o = wide_sum[EXT_W-1] ? NEG_FS : POS_FS;
        end else begin
            sum_o = wide_sum[SAMPLE_W-1:0];
        end
    end
endmodule

// File: rtl/mon_mix_path.sv
// Monitor mix path top: per channel, attenuates the capture sample by the
// shared code, adds it to the playback sample with saturation and registers
// the result. The capture inputs are only read. Reset is synchronous, active low.
// Assumes both sources already run at the same sample rate.
module mon_mix_path
    import mon_mix_pkg::*;
#(
    parameter int unsigned SAMPLE_W = DEF_SAMPLE_W,
    parameter int unsigned CODE_W   = DEF_CODE_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] adc_left,
    input  logic signed [SAMPLE_W-1:0] adc_right,
    input  logic signed [SAMPLE_W-1:0] dac_left,
    input  logic signed [SAMPLE_W-1:0] dac_right,
    input  logic        [CODE_W-1:0]   mon_code,
    output logic                       out_valid,
    output logic signed [SAMPLE_W-1:0] mix_left,
    output logic signed [SAMPLE_W-1:0] mix_right
);
    logic signed [SAMPLE_W-1:0] adc_ch [NUM_CH];
    logic signed [SAMPLE_W-1:0] dac_ch [NUM_CH];
    logic signed [SAMPLE_W-1:0] mix_q  [NUM_CH];

    // Map the stereo ports onto channel arrays.
    always_comb begin
        adc_ch[CH_LEFT]  = adc_left;
        adc_ch[CH_RIGHT] = adc_right;
        dac_ch[CH_LEFT]  = dac_left;
        dac_ch[CH_RIGHT] = dac_right;
    end

    assign mix_left  = mix_q[CH_LEFT];
    assign mix_right = mix_q[CH_RIGHT];

    // Valid strobe follows the input strobe by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
        end
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic signed [SAMPLE_W-1:0] scaled;
        logic signed [SAMPLE_W-1:0] summed;

        mon_mix_atten #(
            .SAMPLE_W (SAMPLE_W),
            .CODE_W   (CODE_W)
        ) u_atten (
            .sample_i (adc_ch[ch]),
            .code_i   (mon_code),
            .scaled_o (scaled)
        );

        mon_mix_satadd #(
            .SAMPLE_W (SAMPLE_W)
        ) u_add (
            .a_i   (dac_ch[ch]),
            .b_i   (scaled),
            .sum_o (summed)
        );

        // Capture the saturated sum on each valid sample, hold otherwise.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mix_q[ch] <= '0;
            end else if (in_valid) begin
                mix_q[ch] <= summed;
            end
        end
    end
endmodule

// File: rtl/mon_mix_chk.sv
// Property checker for the monitor mix path, bound to every instance of the top.
// Only observes ports; the mute code is taken as all ones.
module mon_mix_chk #(
    parameter int unsigned SAMPLE_W = 16,
    parameter int unsigned CODE_W   = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       in_valid,
    input logic signed [SAMPLE_W-1:0] adc_left,
    input logic signed [SAMPLE_W-1:0] adc_right,
    input logic signed [SAMPLE_W-1:0] dac_left,
    input logic signed [SAMPLE_W-1:0] dac_right,
    input logic        [CODE_W-1:0]   mon_code,
    input logic                       out_valid,
    input logic signed [SAMPLE_W-1:0] mix_left,
    input logic signed [SAMPLE_W-1:0] mix_right
);
    localparam int unsigned MSB = SAMPLE_W - 1;

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    p_valid_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_code0_unity_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mon_code == '0 && dac_left == '0) |=> mix_left == $past(adc_left));

    p_mute_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mon_code == '1) |=>
            (mix_left == $past(dac_left) && mix_right == $past(dac_right)));

    p_no_wrap_pos_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dac_left[MSB] && !adc_left[MSB] && !dac_right[MSB] && !adc_right[MSB])
            |=> (!mix_left[MSB] && !mix_right[MSB]));

    p_no_wrap_neg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dac_left[MSB] && adc_left[MSB] && dac_right[MSB] && adc_right[MSB])
            |=> (mix_left[MSB] && mix_right[MSB]));

    p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(mix_left) && $stable(mix_right)));
endmodule

bind mon_mix_path mon_mix_chk #(
    .SAMPLE_W (SAMPLE_W),
    .CODE_W   (CODE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .adc_left  (adc_left),
    .adc_right (adc_right),
    .dac_left  (dac_left),
    .dac_right (dac_right),
    .mon_code  (mon_code),
    .out_valid (out_valid),
    .mix_left  (mix_left),
    .mix_right (mix_right)
);

// File: tb/tb_mon_mix_path.sv
// Bench: sweeps every code against edge-heavy capture/playback values and
// checks the registered, saturated mix against integer arithmetic.
module tb_mon_mix_path;
    localparam int CLK_PERIOD = 10;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic signed [15:0] adc_left = '0, adc_right = '0;
    logic signed [15:0] dac_left = '0, dac_right = '0;
    logic        [3:0]  mon_code = '0;
    logic               out_valid;
    logic signed [15:0] mix_left, mix_right;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mon_mix_path dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .adc_left  (adc_left),
        .adc_right (adc_right),
        .dac_left  (dac_left),
        .dac_right (dac_right),
        .mon_code  (mon_code),
        .out_valid (out_valid),
        .mix_left  (mix_left),
        .mix_right (mix_right)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference: shift (or mute), add in wide integers, clamp.
    function automatic int ref_mix(input int adc, input int dac, input int code);
        int contrib;
        int s;
        contrib = (code == 15) ? 0 : (adc >>> code);
        s = dac + contrib;
        if (s > 32767)  s = 32767;
        if (s < -32768) s = -32768;
        return s;
    endfunction

    int adc_set [8] = '{-32768, -32767, -20000, -1, 0, 1, 12345, 32767};
    int dac_set [7] = '{-32768, -30000, -1, 0, 1, 30000, 32767};

    initial begin
        // R1: reset state
        @(negedge clk);
        @(negedge clk);
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 mix_left", int'(mix_left), 0);
        chk("R1 mix_right", int'(mix_right), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 idle out_valid", int'(out_valid), 0);

        for (int c = 0; c < 16; c++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 7; j++) begin
                    logic signed [15:0] al, ar, dl, dr;
                    int el, er;
                    al = 16'(adc_set[i]);
                    dl = 16'(dac_set[j]);
                    ar = ~al;   // R5: opposite-polarity operands on the right
                    dr = ~dl;
                    el = ref_mix(int'(al), int'(dl), c);
                    er = ref_mix(int'(ar), int'(dr), c);
                    adc_left = al; adc_right = ar;
                    dac_left = dl; dac_right = dr;
                    mon_code = 4'(c);
                    in_valid = 1'b1;
                    @(negedge clk);
                    // R9: result visible right after the sampling edge
                    chk("R2 out_valid", int'(out_valid), 1);
                    if (c == 15) begin
                        chk("R4 mute left", int'(mix_left), int'(dl));
                        chk("R4 mute right", int'(mix_right), int'(dr));
                    end else if (int'(dl) + (int'(al) >>> c) > 32767) begin
                        chk("R6 clip high left", int'(mix_left), 32767);
                    end else if (int'(dl) + (int'(al) >>> c) < -32768) begin
                        chk("R7 clip low left", int'(mix_left), -32768);
                    end else begin
                        chk("R3 shift left", int'(mix_left), el);
                    end
                    chk("R5 R9 left", int'(mix_left), el);
                    chk("R5 R9 right", int'(mix_right), er);
                    // R8: idle cycle with changed data must not move outputs
                    if (j == 3) begin
                        in_valid = 1'b0;
                        adc_left = 16'sh1234; adc_right = -16'sh0777;
                        dac_left = -16'sh4000; dac_right = 16'sh2222;
                        mon_code = 4'd0;
                        @(negedge clk);
                        chk("R2 drop out_valid", int'(out_valid), 0);
                        chk("R8 hold left", int'(mix_left), el);
                        chk("R8 hold right", int'(mix_right), er);
                    end
                end
            end
        end

        // R1: reset reasserted mid-run clears outputs
        in_valid = 1'b1;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 rereset out_valid", int'(out_valid), 0);
        chk("R1 rereset mix_left", int'(mix_left), 0);
        rst_n = 1'b1;
        in_valid = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule